// File: doc/BRIEF.md
# Nested Hardware Loop Controller

This block is the loop sequencer that sits beside the program counter of a DSP core. It lets a loop repeat with no branch instruction at the end. A loop-start command arrives together with the fetch of the instruction that carries it, and it brings an iteration count and the address of the loop's last instruction. The loop body starts at the next address. The controller keeps up to four such loops on a small stack, one independent counter per nesting level. On every fetch it compares the fetched PC with the last-instruction address of the innermost loop. On a match it either sends the next PC back to the body start and decrements that level's count, or it drops the level and lets the PC fall through.

The fetch unit drives the current PC and a fetch strobe. It uses `next_pc_o` as its sequential successor, unless a branch or an interrupt overrides it. The interrupt controller sends a pulse when a service routine is entered and another when it returns. While the routine runs, the loops that were active at entry are frozen and never match. Loops that the routine starts itself behave normally. After the return, the interrupted loop carries on with the count it had.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset the stack is empty (`depth_o` = 0), `redirect_o`, `loop_done_o` and `overflow_o` are low, and `next_pc_o` = `pc_i` + 1.
- R2: A fetch with `push_i` high on a stack that is not full adds a level with start address `pc_i` + 1, end address `push_end_i` and count `push_count_i`. `depth_o` rises by one after the clock edge. A push has priority over an end-address match in the same fetch.
- R3: A fetch whose `pc_i` equals the innermost end address, with a remaining count above one, raises `redirect_o`, drives `next_pc_o` with that level's start address, and decrements that level's count. `depth_o` is unchanged.
- R4: A fetch at the innermost end address with a remaining count of one raises `loop_done_o`, drives `next_pc_o` = `pc_i` + 1, and removes the level. `depth_o` falls by one after the edge.
- R5: A loop whose end address equals its start address (a one-instruction body) redirects on consecutive fetches of that same address, once per iteration.
- R6: Up to four loops nest. Each level keeps its own count, and only the innermost level is compared.
- R7: A push while four levels are held raises `overflow_o` in that cycle. The stack and `depth_o` stay unchanged, and `next_pc_o` = `pc_i` + 1.
- R8: After an `irq_enter_i` pulse and until an `irq_return_i` pulse, no level that was present at entry can match. Levels pushed inside the routine match normally. After the return, the interrupted loop resumes with its remaining count.
- R9: A pushed count of zero runs the body exactly once.
- R10: With `fetch_i` low, `redirect_o` and `loop_done_o` stay low and no count or level changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_i | input | 1 | An instruction at `pc_i` is fetched this cycle |
| pc_i | input | 16 | Address of the current fetch |
| push_i | input | 1 | Fetched instruction is a loop-start command |
| push_count_i | input | 16 | Iteration count of the new loop |
| push_end_i | input | 16 | Address of the new loop's last instruction |
| irq_enter_i | input | 1 | Pulse: service routine entered |
| irq_return_i | input | 1 | Pulse: service routine returned |
| next_pc_o | output | 16 | Successor address for the fetch unit |
| redirect_o | output | 1 | Loop branch back taken this fetch |
| loop_done_o | output | 1 | Innermost loop finished this fetch |
| overflow_o | output | 1 | Push refused because four levels are held |
| depth_o | output | 3 | Number of active levels |

## Verification
`next_pc_o`, `redirect_o`, `loop_done_o` and `overflow_o` are combinational and are due in the same cycle as the fetch that causes them. A push, decrement or pop shows in `depth_o` only after the next clock edge. The driver applies each fetch just after a falling edge and queues the expected outputs, computed from a behavioural loop-stack model. The expected depth in each item is the model's depth before that fetch. The monitor samples 2 ns after the same falling edge, well before the rising edge. Each stack change is therefore checked one fetch after its cause, through `depth_o`, and through where the PC goes next.

// File: rtl/hwloop_pkg.sv
// Package: shared types for the nested hardware loop controller.
// Assumes: nothing beyond a single clock domain.
package hwloop_pkg;
    // What the end-address comparator decides for the current fetch.
    typedef enum logic [1:0] {
        ACT_SEQ  = 2'd0,   // fall through to pc + 1
        ACT_BACK = 2'd1,   // branch back to the loop start, count down
        ACT_EXIT = 2'd2    // last pass: drop the level, fall through
    } loop_act_e;
endpackage

// File: rtl/hwloop_stack.sv
// Module: hwloop_stack
// Holds up to DEPTH loop levels (start, end, remaining count), each with its
// own counter. Exposes the innermost level. Assumes push_i already includes
// the fetch strobe, and that dec_i and pop_i only arrive when a level exists.
module hwloop_stack #(
    parameter int AW    = 16,
    parameter int CW    = 16,
    parameter int DEPTH = 4,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [AW-1:0] push_start_i,
    input  logic [AW-1:0] push_end_i,
    input  logic [CW-1:0] push_cnt_i,
    input  logic          dec_i,
    input  logic          pop_i,
    output logic [AW-1:0] top_start_o,
    output logic [AW-1:0] top_end_o,
    output logic [CW-1:0] top_cnt_o,
    output logic [PW-1:0] depth_o,
    output logic          full_o
);
    logic [PW-1:0] depth_q;
    logic [AW-1:0] lvl_start [DEPTH];
    logic [AW-1:0] lvl_end   [DEPTH];
    logic [CW-1:0] lvl_cnt   [DEPTH];
    logic          push_ok;

    assign full_o  = (depth_q == PW'(DEPTH));
    assign push_ok = push_i && !full_o;
    assign depth_o = depth_q;

    // Level pointer: grows on an accepted push, shrinks on a pop.
    always_ff @(posedge clk) begin
        if (!rst_n)       depth_q <= '0;
        else if (push_ok) depth_q <= depth_q + 1'b1;
        else if (pop_i)   depth_q <= depth_q - 1'b1;
    end

    // One register set per nesting level, each with its own down-counter.
    for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_start[i] <= '0;
                lvl_end[i]   <= '0;
                lvl_cnt[i]   <= '0;
            end else if (push_ok && depth_q == PW'(i)) begin
                lvl_start[i] <= push_start_i;
                lvl_end[i]   <= push_end_i;
                lvl_cnt[i]   <= (push_cnt_i == '0) ? CW'(1) : push_cnt_i;
            end else if (dec_i && depth_q == PW'(i + 1)) begin
                lvl_cnt[i]   <= lvl_cnt[i] - 1'b1;
            end
        end
    end

    // Innermost-level select for the comparator.
    always_comb begin
        top_start_o = '0;
        top_end_o   = '0;
        top_cnt_o   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (depth_q == PW'(i + 1)) begin
                top_start_o = lvl_start[i];
                top_end_o   = lvl_end[i];
                top_cnt_o   = lvl_cnt[i];
            end
        end
    end

    // R6: the level pointer never passes the stack size.
    a_r6_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q <= PW'(DEPTH));

    // R2: an accepted push adds exactly one level.
    a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok |=> depth_q == $past(depth_q) + 1'b1);

    // R7: a refused push leaves the level count alone.
    a_r7_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o) |=> $stable(depth_q));
endmodule

// File: rtl/hwloop_match.sv
// Module: hwloop_match
// Compares the fetched PC with the innermost end address and picks the
// successor PC. Assumes the stack outputs are valid whenever have_top_i is set.
module hwloop_match
    import hwloop_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          fetch_i,
    input  logic          push_i,
    input  logic          have_top_i,
    input  logic          match_en_i,
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] top_start_i,
    input  logic [AW-1:0] top_end_i,
    input  logic [CW-1:0] top_cnt_i,
    output loop_act_e     act_o,
    output logic [AW-1:0] next_pc_o
);
    logic hit;

    // End-address hit: only on a real fetch that is not itself a loop start.
    assign hit = fetch_i && !push_i && have_top_i && match_en_i && (pc_i == top_end_i);

    // Decide between falling through, branching back and leaving the loop.
    always_comb begin
        if (!hit)                 act_o = ACT_SEQ;
        else if (top_cnt_i > 1)   act_o = ACT_BACK;
        else                      act_o = ACT_EXIT;
    end

    // Successor address for the fetch unit.
    always_comb begin
        next_pc_o = (act_o == ACT_BACK) ? top_start_i : pc_i + 1'b1;
    end
endmodule

// File: rtl/hwloop_isr_guard.sv
// Module: hwloop_isr_guard
// Records the loop depth at interrupt entry and masks the end-address match
// for the levels at or below it until the routine returns. Assumes a single
// interrupt level, and that the routine finishes its own loops before it returns.
module hwloop_isr_guard #(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enter_i,
    input  logic          return_i,
    input  logic [PW-1:0] depth_i,
    output logic          match_en_o
);
    logic          in_isr_q;
    logic [PW-1:0] base_q;

    // Track whether a routine is running and how deep the loops were at entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_isr_q <= 1'b0;
            base_q   <= '0;
        end else if (enter_i) begin
            in_isr_q <= 1'b1;
            base_q   <= depth_i;
        end else if (return_i) begin
            in_isr_q <= 1'b0;
        end
    end

    // Only levels pushed inside the routine may match.
    assign match_en_o = !in_isr_q || (depth_i > base_q);

    // R8: the routine can never pop the levels it interrupted.
    a_r8_floor_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_isr_q && !enter_i) |-> depth_i >= base_q);
endmodule

// File: rtl/hwloop_ctrl.sv
// Module: hwloop_ctrl (top)
// Zero-overhead nested loop sequencer: a loop stack, an end-address comparator
// and an interrupt guard. Assumes push_i is only meaningful together with fetch_i.
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CW    = 16,
    parameter int DEPTH = 4,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_i,
    input  logic [AW-1:0] pc_i,
    input  logic          push_i,
    input  logic [CW-1:0] push_count_i,
    input  logic [AW-1:0] push_end_i,
    input  logic          irq_enter_i,
    input  logic          irq_return_i,
    output logic [AW-1:0] next_pc_o,
    output logic          redirect_o,
    output logic          loop_done_o,
    output logic          overflow_o,
    output logic [PW-1:0] depth_o
);
    logic          push_f;
    logic          full;
    logic          match_en;
    logic [AW-1:0] top_start, top_end;
    logic [CW-1:0] top_cnt;
    loop_act_e     act;

    assign push_f      = push_i && fetch_i;
    assign redirect_o  = (act == ACT_BACK);
    assign loop_done_o = (act == ACT_EXIT);
    assign overflow_o  = push_f && full;

    hwloop_stack #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_stack (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (push_f),
        .push_start_i (pc_i + 1'b1),
        .push_end_i   (push_end_i),
        .push_cnt_i   (push_count_i),
        .dec_i        (redirect_o),
        .pop_i        (loop_done_o),
        .top_start_o  (top_start),
        .top_end_o    (top_end),
        .top_cnt_o    (top_cnt),
        .depth_o      (depth_o),
        .full_o       (full)
    );

    hwloop_match #(.AW(AW), .CW(CW)) u_match (
        .fetch_i      (fetch_i),
        .push_i       (push_i),
        .have_top_i   (depth_o != '0),
        .match_en_i   (match_en),
        .pc_i         (pc_i),
        .top_start_i  (top_start),
        .top_end_i    (top_end),
        .top_cnt_i    (top_cnt),
        .act_o        (act),
        .next_pc_o    (next_pc_o)
    );

    hwloop_isr_guard #(.PW(PW)) u_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .enter_i      (irq_enter_i),
        .return_i     (irq_return_i),
        .depth_i      (depth_o),
        .match_en_o   (match_en)
    );

    // R10: no loop action without a fetch.
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_i |-> (!redirect_o && !loop_done_o));

    // R3: a branch back keeps the level.
    a_r3_back_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> $stable(depth_o));

    // R4: leaving a loop drops exactly one level.
    a_r4_exit_pops: assert property (@(posedge clk) disable iff (!rst_n)
        loop_done_o |=> depth_o == $past(depth_o) - 1'b1);

    // R7: overflow and a loop action never coincide.
    a_r7_ovf_alone: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> (!redirect_o && !loop_done_o));
endmodule

// File: tb/test_hwloop_ctrl.sv
module test_hwloop_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch = 1'b0, push = 1'b0, ien = 1'b0, iret = 1'b0;
    logic [15:0] pc = '0, pcnt = '0, pend = '0;
    logic [15:0] next_pc;
    logic        redirect, done, ovf;
    logic [2:0]  depth;

    always #2.5 clk = ~clk;

    hwloop_ctrl i_hwloop_ctrl (
        .clk(clk), .rst_n(rst_n), .fetch_i(fetch), .pc_i(pc), .push_i(push),
        .push_count_i(pcnt), .push_end_i(pend), .irq_enter_i(ien),
        .irq_return_i(iret), .next_pc_o(next_pc), .redirect_o(redirect),
        .loop_done_o(done), .overflow_o(ovf), .depth_o(depth)
    );

    typedef struct packed {
        logic [15:0] np;
        logic        tk;
        logic        ex;
        logic        ov;
        logic [2:0]  dp;
    } exp_t;

    exp_t  q_exp[$];
    string q_tag[$];
    int    checks = 0, errors = 0;
    bit    finished = 0;

    // behavioural loop-stack model
    int ms_s[4], ms_e[4], ms_c[4];
    int md = 0, m_base = 0;
    bit m_isr = 0;
    int cur_pc = 0;
    // program: which addresses carry loop-start commands
    int tp_pc[16], tp_cnt[16], tp_end[16];
    int tp_n = 0;

    task automatic clear_prog();
        tp_n = 0;
    endtask

    task automatic add_push(input int a, input int c, input int e);
        tp_pc[tp_n] = a; tp_cnt[tp_n] = c; tp_end[tp_n] = e; tp_n++;
    endtask

    // Driver: apply one cycle and queue its expected outputs.
    task automatic step(input bit fet, input bit ie, input bit ir, input string tag);
        bit pu = 0; int c = 0; int e = 0; exp_t x;
        @(negedge clk);
        for (int k = 0; k < tp_n; k++)
            if (tp_pc[k] == cur_pc) begin pu = 1; c = tp_cnt[k]; e = tp_end[k]; end
        pu = pu && fet;
        fetch = fet; pc = 16'(cur_pc); push = pu; pcnt = 16'(c); pend = 16'(e);
        ien = ie; iret = ir;
        x.dp = 3'(md); x.tk = 0; x.ex = 0; x.np = 16'(cur_pc + 1);
        x.ov = pu && (md == 4);
        if (fet) begin
            if (pu) begin
                if (md < 4) begin
                    ms_s[md] = cur_pc + 1; ms_e[md] = e; ms_c[md] = (c == 0) ? 1 : c; md++;
                end
            end else if (md > 0 && (!m_isr || md > m_base) && cur_pc == ms_e[md-1]) begin
                if (ms_c[md-1] > 1) begin
                    x.tk = 1; x.np = 16'(ms_s[md-1]); ms_c[md-1]--;
                end else begin
                    x.ex = 1; md--;
                end
            end
        end
        if (ie) begin m_isr = 1; m_base = int'(x.dp); end
        else if (ir) m_isr = 0;
        q_exp.push_back(x);
        q_tag.push_back(tag);
        if (fet) cur_pc = int'(x.np);
    endtask

    task automatic run_until(input int stop, input int maxn, input string tag);
        for (int n = 0; n < maxn && cur_pc != stop; n++) step(1, 0, 0, tag);
    endtask

    task automatic cmp(input string tag, input string f, input int act, input int ex);
        checks++;
        if (act != ex) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, f, act, ex);
        end
    endtask

    // Monitor: sample away from the rising edge and compare with the queue.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q_exp.size() > 0) begin
                exp_t x; string t;
                x = q_exp.pop_front(); t = q_tag.pop_front();
                cmp(t, "next_pc",  int'(next_pc),  int'(x.np));
                cmp(t, "redirect", int'(redirect), int'(x.tk));
                cmp(t, "done",     int'(done),     int'(x.ex));
                cmp(t, "overflow", int'(ovf),      int'(x.ov));
                cmp(t, "depth",    int'(depth),    int'(x.dp));
            end
        end
    end

    // Watchdog
    initial begin
        #1000000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cur_pc = 5;
        step(1, 0, 0, "R1");
        // R2 R3 R4: multi-instruction body, count 3, body 11..12
        clear_prog(); add_push(10, 3, 12); cur_pc = 10;
        run_until(12, 10, "R2_R3");
        // R10: idle cycle on the end address changes nothing
        step(0, 0, 0, "R10");
        run_until(13, 20, "R3_R4");
        step(1, 0, 0, "R4");
        // R5: one-instruction body at 21, four passes
        clear_prog(); add_push(20, 4, 21); cur_pc = 20;
        run_until(22, 20, "R5");
        step(1, 0, 0, "R5");
        // R9: zero count runs once
        clear_prog(); add_push(30, 0, 32); cur_pc = 30;
        run_until(33, 20, "R9");
        step(1, 0, 0, "R9");
        // R6: four nested levels, innermost one-instruction
        clear_prog();
        add_push(40, 2, 50); add_push(41, 2, 48); add_push(42, 2, 46); add_push(43, 2, 44);
        cur_pc = 40;
        run_until(51, 400, "R6");
        step(1, 0, 0, "R6");
        // R7: fifth push refused
        clear_prog();
        add_push(60, 2, 70); add_push(61, 1, 69); add_push(62, 1, 68);
        add_push(63, 1, 67); add_push(64, 1, 66);
        cur_pc = 60;
        run_until(71, 400, "R7");
        step(1, 0, 0, "R7");
        // R8: interrupt inside a loop, routine lands on the outer end address
        clear_prog(); add_push(80, 3, 83); cur_pc = 80;
        run_until(82, 10, "R8");
        step(0, 1, 0, "R8");
        cur_pc = 83; add_push(84, 2, 85);
        run_until(86, 20, "R8");
        step(0, 0, 1, "R8");
        cur_pc = 82;
        run_until(84, 40, "R8");
        step(0, 0, 0, "R8");
        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule